// File: doc/BRIEF.md
# Oscillator Trim Binary-Search Calibrator

This controller tunes a trimmable on-chip oscillator so that its measured frequency lands as close as possible to a requested value. The caller presents a target frequency in MHz and pulses a start strobe. The block converts that frequency to the count an external frequency meter would report, then measures the trim code already applied. If that count is inside the acceptance window, the block stops there. Otherwise it runs a bisection over the full trim range. Every code it applies is held for a programmable settle time before a measurement is requested.

When the bisection has narrowed to two adjacent codes, both are measured and the one with the smaller absolute count error is kept. The block then measures that code a final time and judges it against a ±4% window. A zero count from the meter is treated as a dead measurement and ends the run as a failure. The result code stays on the trim output, so the next calibration starts from it.

Top module: `osc_trim_cal`

## Requirements
- R1: On an accepted start, the target count is floor(target_mhz × 1024 / 26), held for the whole run and used for every comparison.
- R2: The first measurement of a run is taken at the trim code already applied. If its count is strictly inside the window, the run ends after that single measurement with pass=1 and that code as the result.
- R3: Otherwise the search bounds start at lo=0 and hi=2^TRIM_W−1. Each step applies mid=floor((lo+hi)/2). The bisection ends, without measuring, as soon as mid equals lo.
- R4: After each bisection measurement, a count strictly greater than the target moves hi to mid; any other count moves lo to mid.
- R5: After the bisection, the block measures lo and then hi. It selects lo only if lo's absolute error is strictly smaller, so a tie selects hi. It then measures the selected code once more.
- R6: meas_start is a single-cycle pulse. It is raised only after the trim output has held its value for at least SETTLE_CYC clock cycles.
- R7: pass is 1 exactly when the last count is greater than floor(T×960/1000) and less than floor(T×1040/1000), where T is the target count.
- R8: A meas_count of zero ends the run at once with pass=0. The result code is the code that was being measured.
- R9: A start pulse while a run is in progress is ignored and does not change the sequence of measured codes.
- R10: After reset, trim_code=RESET_TRIM, and meas_start, done, pass and final_code are all 0.
- R11: done is a one-cycle pulse. When it is high, trim_code equals final_code, and final_code and pass hold until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calibration (accepted only when idle) |
| target_mhz | input | MHZ_W | Requested oscillator frequency in MHz |
| trim_code | output | TRIM_W | Trim code driven to the oscillator |
| meas_start | output | 1 | One-cycle request to the frequency meter |
| meas_valid | input | 1 | Meter result strobe |
| meas_count | input | CNT_W | Meter count (0 means no valid measurement) |
| done | output | 1 | One-cycle end-of-run pulse |
| final_code | output | TRIM_W | Code chosen by the last run |
| pass | output | 1 | Last run ended inside the acceptance window |

## Verification
The bench builds the block with TRIM_W=5, SETTLE_CYC=3 and RESET_TRIM=16. A five-step bisection over 32 codes is short enough to replay hundreds of full calibrations, each against a bench-side reference of the whole measured-code sequence. Two linear oscillator models are swept across target frequencies, which reaches both range ends, the skip-on-first-measure path, out-of-range targets that must fail, and a constructed exact tie between the two final neighbours. A stuck-at-zero meter and a start pulse during a busy run complete the coverage.

// File: rtl/osc_cal_pkg.sv
package osc_cal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_REQ,
    ST_WAIT,
    ST_STEP
  } cal_state_t;

  typedef enum logic [2:0] {
    PH_CHECK,
    PH_BISECT,
    PH_LOW,
    PH_HIGH,
    PH_FINAL
  } cal_phase_t;

  localparam int unsigned METER_SCALE  = 1024;
  localparam int unsigned METER_REFMHZ = 26;
  localparam int unsigned TOL_PERMILLE = 40;

  // Expected meter count for a frequency given in MHz.
  function automatic logic [31:0] mhz_to_count(input logic [31:0] mhz);
    return (mhz * METER_SCALE) / METER_REFMHZ;
  endfunction

  // Exclusive lower edge of the acceptance window.
  function automatic logic [31:0] win_floor(input logic [31:0] tgt);
    return (tgt * (1000 - TOL_PERMILLE)) / 1000;
  endfunction

  // Exclusive upper edge of the acceptance window.
  function automatic logic [31:0] win_ceil(input logic [31:0] tgt);
    return (tgt * (1000 + TOL_PERMILLE)) / 1000;
  endfunction

  function automatic logic [31:0] abs_gap(input logic [31:0] a, input logic [31:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

endpackage

// File: rtl/osc_cal_window.sv
module osc_cal_window #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] target,
  input  logic [CNT_W-1:0] count,
  output logic             in_tol,
  output logic             above,
  output logic [CNT_W-1:0] abs_err
);
  import osc_cal_pkg::*;

  logic [31:0] tgt32, cnt32, lo_edge, hi_edge, err32;

  always_comb begin
    tgt32   = 32'(target);
    cnt32   = 32'(count);
    lo_edge = win_floor(tgt32);
    hi_edge = win_ceil(tgt32);
    err32   = abs_gap(cnt32, tgt32);
    in_tol  = (cnt32 > lo_edge) && (cnt32 < hi_edge);
    above   = cnt32 > tgt32;
    abs_err = err32[CNT_W-1:0];
  end

endmodule

// File: rtl/osc_cal_settle.sv
module osc_cal_settle #(
  parameter int SETTLE_CYC = 2600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic ready
);
  localparam int CW = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (kick)           cnt_q <= CW'(SETTLE_CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign ready = (cnt_q == '0);

  // R6: an idle timer stays idle until kicked again
  a_r6_timer_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (!kick && cnt_q == '0) |=> (cnt_q == '0));

  // R6: a running timer only counts down
  a_r6_timer_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!kick && cnt_q != '0) |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/osc_cal_range.sv
module osc_cal_range #(
  parameter int TRIM_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              update,
  input  logic              above,
  output logic [TRIM_W-1:0] lo,
  output logic [TRIM_W-1:0] hi,
  output logic [TRIM_W-1:0] mid,
  output logic              converged
);
  localparam logic [TRIM_W-1:0] CODE_MAX = {TRIM_W{1'b1}};

  logic [TRIM_W:0] sum;

  always_comb begin
    sum       = {1'b0, lo} + {1'b0, hi};
    mid       = sum[TRIM_W:1];
    converged = (mid == lo);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= CODE_MAX;
    end else if (init) begin
      lo <= '0;
      hi <= CODE_MAX;
    end else if (update) begin
      if (above) hi <= mid;
      else       lo <= mid;
    end
  end

  // R3: bounds never cross
  a_r3_ordered: assert property (@(posedge clk) disable iff (!rst_n) lo <= hi);

  // R3: the probe lies within the bounds
  a_r3_mid_inside: assert property (@(posedge clk) disable iff (!rst_n)
    (mid >= lo) && (mid <= hi));

  // R4: every narrowing step strictly shrinks the interval
  a_r4_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (update && !init) |=> ((hi - lo) < $past(hi - lo)));

  // R3: a fresh search spans the full trim range
  a_r3_full_span: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (lo == '0 && hi == CODE_MAX));

endmodule

// File: rtl/osc_trim_cal.sv
module osc_trim_cal #(
  parameter int TRIM_W     = 7,
  parameter int CNT_W      = 16,
  parameter int MHZ_W      = 10,
  parameter int SETTLE_CYC = 2600,
  parameter int RESET_TRIM = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MHZ_W-1:0]  target_mhz,
  output logic [TRIM_W-1:0] trim_code,
  output logic              meas_start,
  input  logic              meas_valid,
  input  logic [CNT_W-1:0]  meas_count,
  output logic              done,
  output logic [TRIM_W-1:0] final_code,
  output logic              pass
);
  import osc_cal_pkg::*;

  cal_state_t        state_q, st_n;
  cal_phase_t        phase_q, ph_n;
  logic [TRIM_W-1:0] trim_q, trim_n, final_q;
  logic [CNT_W-1:0]  tgt_q, err_lo_q;
  logic              pass_q, done_q;

  // Named internal events
  logic trim_load, settle_kick, settle_ready, tgt_load;
  logic rng_init, rng_upd, err_cap, finish, fin_pass;
  logic meas_zero, in_tol, above;
  logic [CNT_W-1:0]  abs_err;
  logic [TRIM_W-1:0] rng_lo, rng_hi, rng_mid;
  logic              converged;

  osc_cal_window #(.CNT_W(CNT_W)) u_window (
    .target (tgt_q),
    .count  (meas_count),
    .in_tol (in_tol),
    .above  (above),
    .abs_err(abs_err)
  );

  osc_cal_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk  (clk),
    .rst_n(rst_n),
    .kick (settle_kick),
    .ready(settle_ready)
  );

  osc_cal_range #(.TRIM_W(TRIM_W)) u_range (
    .clk      (clk),
    .rst_n    (rst_n),
    .init     (rng_init),
    .update   (rng_upd),
    .above    (above),
    .lo       (rng_lo),
    .hi       (rng_hi),
    .mid      (rng_mid),
    .converged(converged)
  );

  assign meas_zero = (meas_count == '0);

  always_comb begin
    st_n      = state_q;
    ph_n      = phase_q;
    trim_n    = trim_q;
    trim_load = 1'b0;
    tgt_load  = 1'b0;
    rng_init  = 1'b0;
    rng_upd   = 1'b0;
    err_cap   = 1'b0;
    finish    = 1'b0;
    fin_pass  = 1'b0;
    settle_kick = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          tgt_load    = 1'b1;
          settle_kick = 1'b1;
          ph_n        = PH_CHECK;
          st_n        = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (settle_ready) st_n = ST_REQ;
      end
      ST_REQ: st_n = ST_WAIT;
      ST_WAIT: begin
        if (meas_valid) begin
          if (meas_zero) begin
            finish = 1'b1;
          end else begin
            case (phase_q)
              PH_CHECK: begin
                if (in_tol) begin
                  finish   = 1'b1;
                  fin_pass = 1'b1;
                end else begin
                  rng_init = 1'b1;
                  ph_n     = PH_BISECT;
                  st_n     = ST_STEP;
                end
              end
              PH_BISECT: begin
                rng_upd = 1'b1;
                st_n    = ST_STEP;
              end
              PH_LOW: begin
                err_cap   = 1'b1;
                trim_n    = rng_hi;
                trim_load = 1'b1;
                ph_n      = PH_HIGH;
                st_n      = ST_SETTLE;
              end
              PH_HIGH: begin
                trim_n    = (err_lo_q < abs_err) ? rng_lo : rng_hi;
                trim_load = 1'b1;
                ph_n      = PH_FINAL;
                st_n      = ST_SETTLE;
              end
              default: begin
                finish   = 1'b1;
                fin_pass = in_tol;
              end
            endcase
          end
          if (finish) st_n = ST_IDLE;
        end
      end
      ST_STEP: begin
        trim_load = 1'b1;
        st_n      = ST_SETTLE;
        if (converged) begin
          trim_n = rng_lo;
          ph_n   = PH_LOW;
        end else begin
          trim_n = rng_mid;
          ph_n   = PH_BISECT;
        end
      end
      default: st_n = ST_IDLE;
    endcase
    if (trim_load) settle_kick = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      phase_q  <= PH_CHECK;
      trim_q   <= TRIM_W'(RESET_TRIM);
      tgt_q    <= '0;
      err_lo_q <= '0;
      final_q  <= '0;
      pass_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q <= st_n;
      phase_q <= ph_n;
      done_q  <= finish;
      if (trim_load) trim_q   <= trim_n;
      if (tgt_load)  tgt_q    <= CNT_W'(mhz_to_count(32'(target_mhz)));
      if (err_cap)   err_lo_q <= abs_err;
      if (finish) begin
        final_q <= trim_q;
        pass_q  <= fin_pass;
      end
    end
  end

  assign trim_code  = trim_q;
  assign meas_start = (state_q == ST_REQ);
  assign done       = done_q;
  assign final_code = final_q;
  assign pass       = pass_q;

  // Observation logic for the settle-time check
  logic [TRIM_W-1:0] trim_prev;
  logic [31:0]       trim_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim_prev <= TRIM_W'(RESET_TRIM);
      trim_age  <= '0;
    end else begin
      trim_prev <= trim_q;
      if (trim_q != trim_prev)     trim_age <= '0;
      else if (trim_age != '1)     trim_age <= trim_age + 1'b1;
    end
  end

  // R6: the meter is never asked before the code has settled
  a_r6_settled: assert property (@(posedge clk) disable iff (!rst_n)
    meas_start |-> (trim_age >= 32'(SETTLE_CYC)));

  // R6: the request is a single-cycle pulse
  a_r6_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    meas_start |=> !meas_start);

  // R11: done is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: the oscillator is left on the reported code
  a_r11_final_match: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (final_code == trim_code));

  // R11: result outputs hold between runs
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ($stable(final_code) && $stable(pass)) || done);

  // R8: a dead meter ends the run as a failure
  a_r8_zero_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && meas_valid && meas_zero) |=> (done && !pass));

  // R5: the code confirmed last is one of the two final neighbours
  a_r5_pick_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETTLE && phase_q == PH_FINAL) |-> (trim_q == rng_lo || trim_q == rng_hi));

  // R9: a start pulse mid-run never reloads the target
  a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(tgt_q));

endmodule

// File: tb/osc_trim_cal_tb.sv
module osc_trim_cal_tb_top;
  localparam int TW = 5;
  localparam int CW = 16;
  localparam int MW = 10;
  localparam int SC = 3;
  localparam int RT = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [MW-1:0] target_mhz = '0;
  logic [TW-1:0] trim_code;
  logic          meas_start;
  logic          meas_valid = 1'b0;
  logic [CW-1:0] meas_count = '0;
  logic          done;
  logic [TW-1:0] final_code;
  logic          pass;

  always #10 clk = ~clk;

  osc_trim_cal #(.TRIM_W(TW), .CNT_W(CW), .MHZ_W(MW), .SETTLE_CYC(SC), .RESET_TRIM(RT)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .target_mhz(target_mhz),
    .trim_code(trim_code), .meas_start(meas_start), .meas_valid(meas_valid),
    .meas_count(meas_count), .done(done), .final_code(final_code), .pass(pass)
  );

  int checks = 0;
  int fails  = 0;

  // Oscillator / meter model
  int m_off = 3000;
  int m_slope = 150;
  bit m_zero = 1'b0;
  int obs_seq[32];
  int obs_len = 0;
  bit settle_bad = 1'b0;

  // Reference results
  int exp_seq[32];
  int exp_len;
  int exp_code;
  int exp_pass;
  int ref_cur = RT;

  function automatic int osc_count(int code);
    return m_zero ? 0 : (m_off + m_slope * code);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    int pend = 0;
    int pcode = 0;
    int age = 0;
    logic [TW-1:0] prev = TW'(RT);
    forever begin
      @(negedge clk);
      if (trim_code !== prev) age = 0; else age++;
      prev = trim_code;
      meas_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          meas_valid = 1'b1;
          meas_count = CW'(osc_count(pcode));
        end
      end
      if (meas_start === 1'b1) begin
        if (obs_len < 32) obs_seq[obs_len] = int'(trim_code);
        obs_len++;
        if (age < SC) settle_bad = 1'b1;
        pcode = int'(trim_code);
        pend = 2;
      end
    end
  end

  // Bench reference of the whole calibration
  task automatic ref_run(int mhz);
    int t, wlo, whi, c, mn, mx, md, c0, c1, e0, e1, pick;
    bit fin;
    t   = (mhz * 1024) / 26;
    wlo = (t * 960) / 1000;
    whi = (t * 1040) / 1000;
    exp_len = 0;
    fin = 1'b0;
    exp_seq[exp_len++] = ref_cur;
    c = osc_count(ref_cur);
    if (c == 0) begin
      exp_code = ref_cur; exp_pass = 0; fin = 1'b1;
    end else if (c > wlo && c < whi) begin
      exp_code = ref_cur; exp_pass = 1; fin = 1'b1;
    end
    if (!fin) begin
      mn = 0;
      mx = (1 << TW) - 1;
      forever begin
        md = (mn + mx) / 2;
        if (md == mn) break;
        exp_seq[exp_len++] = md;
        if (osc_count(md) > t) mx = md; else mn = md;
      end
      exp_seq[exp_len++] = mn;
      c0 = osc_count(mn);
      exp_seq[exp_len++] = mx;
      c1 = osc_count(mx);
      e0 = (c0 > t) ? c0 - t : t - c0;
      e1 = (c1 > t) ? c1 - t : t - c1;
      pick = (e0 < e1) ? mn : mx;
      exp_seq[exp_len++] = pick;
      c = osc_count(pick);
      exp_code = pick;
      exp_pass = (c > wlo && c < whi) ? 1 : 0;
    end
    ref_cur = exp_code;
  endtask

  task automatic run_cal(int mhz, bit poke, string tag);
    int n = 0;
    bit seq_ok;
    ref_run(mhz);
    obs_len = 0;
    settle_bad = 1'b0;
    target_mhz = MW'(mhz);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (done !== 1'b1 && n < 5000) begin
      start = (poke && n == 6) ? 1'b1 : 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(n < 5000, tag, "run completes", n, 0);
    seq_ok = (obs_len == exp_len);
    for (int i = 0; i < exp_len && i < 32; i++)
      if (obs_seq[i] != exp_seq[i]) seq_ok = 1'b0;
    // R1 R3 R4: measured-code sequence follows target and bisection rules
    chk(seq_ok, {tag, " R1 R3 R4"}, "measurement sequence length", obs_len, exp_len);
    chk(int'(final_code) == exp_code, {tag, " R5"}, "final_code", int'(final_code), exp_code);
    chk(int'(pass) == exp_pass, {tag, " R7"}, "pass", int'(pass), exp_pass);
    chk(trim_code == final_code, {tag, " R11"}, "trim_code", int'(trim_code), int'(final_code));
    chk(!settle_bad, {tag, " R6"}, "settle violation", int'(settle_bad), 0);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R11"}, "done after pulse", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(int'(trim_code) == RT, "R10", "trim_code", int'(trim_code), RT);
    chk(meas_start == 1'b0, "R10", "meas_start", int'(meas_start), 0);
    chk(done == 1'b0, "R10", "done", int'(done), 0);
    chk(pass == 1'b0, "R10", "pass", int'(pass), 0);
    chk(final_code == '0, "R10", "final_code", int'(final_code), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep A: low-slope linear oscillator
    m_off = 3000; m_slope = 150;
    for (int f = 60; f <= 200; f++) run_cal(f, 1'b0, "sweepA");

    // R2: repeating a target reuses the current code with one measurement
    run_cal(120, 1'b0, "R2a");
    run_cal(120, 1'b0, "R2b");
    chk(obs_len == 1 && pass == 1'b1, "R2", "measurements on repeat", obs_len, 1);

    // Sweep B: steep oscillator
    m_off = 200; m_slope = 700;
    for (int f = 10; f <= 250; f += 3) run_cal(f, 1'b0, "sweepB");

    // R5 tie: f(15)=5832 and f(16)=5982 straddle target 5907 by 75 each
    m_off = 3000; m_slope = 150;
    run_cal(60, 1'b0, "pre_tie");
    m_off = 3582;
    run_cal(150, 1'b0, "tie");
    chk(int'(final_code) == 16, "R5", "tie picks upper bound", int'(final_code), 16);

    // R7: unreachable target fails at the top code
    m_off = 3000;
    run_cal(600, 1'b0, "range");
    chk(pass == 1'b0 && int'(final_code) == (1 << TW) - 1, "R7", "unreachable code",
        int'(final_code), (1 << TW) - 1);

    // R9: start pulse during a busy run
    run_cal(60, 1'b0, "pre_busy");
    run_cal(170, 1'b1, "R9");

    // R8: dead meter
    m_zero = 1'b1;
    run_cal(150, 1'b0, "R8");
    chk(obs_len == 1 && pass == 1'b0, "R8", "measurements on zero count", obs_len, 1);
    m_zero = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule